// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host bus and the write engine of a NOR-style flash controller. Every bus write carries an 8-bit command code in the low byte of a 16-bit data word. The decoder sorts these writes into single-cycle commands and two-cycle setup/confirm pairs. It then issues one-cycle request pulses, each with a captured address and data word, to a separate write engine. The engine reports its progress only through a busy level, and the decoder treats a falling edge of busy as the end of an operation.

The decoder also owns the read-mode select that the read path uses (array, identifier, query or status) and a small status register. While a program or erase is running, the only command the decoder accepts is the suspend code. Once an operation is suspended, it accepts a resume and the read-mode codes. A malformed two-cycle sequence is dropped and reported through an error bit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), `sr_bits` is 8'h80 and `req_stb` is low.
- R2: In idle, a write whose low byte is FFh, 90h, 98h or 70h sets `rd_mode` to 0 (array), 1 (identifier), 2 (query) or 3 (status) on the next clock, whatever the upper byte holds. Any first-cycle code that this list and R3 to R8 do not name is ignored.
- R3: 50h in idle clears status bit 4 (sequence error) on the next clock, and no second cycle is expected.
- R4: 20h followed by D0h at an address in the same block (equal address bits above `BLK_W`) issues op 3 (erase) with the second cycle's address. D0h in another block is a sequence error.
- R5: 40h, or 10h when `ALT_PROG_EN` is set, followed by any word issues op 1 (program) with the second cycle's address and data.
- R6: 30h followed by D0h issues op 2 (fast program).
- R7: 60h followed by 01h, D0h or 2Fh issues op 4 (lock), 5 (unlock) or 6 (lock down).
- R8: C0h followed by the word FFFDh issues op 8 (protection lock). Any other second word issues op 7 (protection program) with that address and data.
- R9: A second cycle that does not complete its setup sets status bit 4, sets `rd_mode` to 3, issues nothing and returns the decoder to idle.
- R10: Every request from R4 to R8 is a one-cycle `req_stb` that appears on the clock after the confirming write. In that same cycle `rd_mode` becomes 3 and status bit 7 (ready) clears. A falling edge of `wsm_busy` sets bit 7 again and returns the decoder to idle, with `rd_mode` left at 3.
- R11: While a program (op 1 or 2) or erase runs, only B0h is accepted. It issues op 9 (suspend), sets bit 7, and sets bit 2 for a program or bit 6 for an erase. Runs of ops 4 to 8 accept no command, and all ignored writes leave every output unchanged.
- R12: While suspended, D0h issues op 10 (resume), clears bit 7 and the suspend bit, sets `rd_mode` to 3 and goes back to the running state. The codes from R2 and R3 work as in idle, and all other codes are ignored.
- R13: A write in the same cycle as the busy falling edge that ends a run is decoded as if the decoder were already idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | AW | Host write address |
| bus_wdata | input | DW | Host write data; bits 7:0 hold the command code |
| wsm_busy | input | 1 | Write engine busy level |
| req_stb | output | 1 | One-cycle request pulse |
| req_op | output | 4 | Request code (1 to 10) |
| req_addr | output | AW | Address captured with the request |
| req_wdata | output | DW | Data word captured with the request |
| rd_mode | output | 2 | Read-mode select: 0 array, 1 identifier, 2 query, 3 status |
| sr_bits | output | 8 | Status: bit 7 ready, bit 6 erase suspended, bit 4 sequence error, bit 2 program suspended |

## Verification
The end of a running operation (the falling edge of `wsm_busy`) and a host write can fall in the same clock. The bench provokes this by dropping busy in exactly the cycle it presents FFh, and again with a 40h setup. The reference model then expects the write to be decoded from idle: the read mode returns to array, or the next word issues a program at once. A write arriving at the completion edge must never be treated as a suspend or be swallowed by the running state.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_PROG   = 4'd1,
        OP_FAST   = 4'd2,
        OP_ERASE  = 4'd3,
        OP_LOCK   = 4'd4,
        OP_UNLOCK = 4'd5,
        OP_LOCKDN = 4'd6,
        OP_PPROG  = 4'd7,
        OP_PLOCK  = 4'd8,
        OP_SUSP   = 4'd9,
        OP_RESUME = 4'd10
    } req_op_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        CL_ARRAY, CL_IDENT, CL_QUERY, CL_STAT, CL_CLEAR,
        CL_ERASE_SU, CL_PROG_SU, CL_FAST_SU, CL_LOCK_SU, CL_PROT_SU,
        CL_SUSPEND, CL_CONFIRM, CL_OTHER
    } cmd_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SECOND, ST_RUN_PROG, ST_RUN_ERASE, ST_RUN_FIXED,
        ST_SUS_PROG, ST_SUS_ERASE
    } fsm_st_e;

    typedef struct packed {
        logic set_ready;
        logic clr_ready;
        logic set_err;
        logic clr_err;
        logic set_psus;
        logic set_esus;
        logic clr_sus;
    } sr_upd_t;

    typedef struct packed {
        logic ready;
        logic esus;
        logic err;
        logic psus;
    } sr_t;

    function automatic logic is_read_cls(cmd_cls_e c);
        return (c == CL_ARRAY) || (c == CL_IDENT) || (c == CL_QUERY) || (c == CL_STAT);
    endfunction

    function automatic rd_mode_e mode_of(cmd_cls_e c);
        case (c)
            CL_IDENT: return RM_IDENT;
            CL_QUERY: return RM_QUERY;
            CL_STAT:  return RM_STATUS;
            default:  return RM_ARRAY;
        endcase
    endfunction

    function automatic logic is_run(fsm_st_e s);
        return (s == ST_RUN_PROG) || (s == ST_RUN_ERASE) || (s == ST_RUN_FIXED);
    endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
#(
    parameter bit ALT_PROG_EN = 1'b1
) (
    input  logic [7:0] code,
    output cmd_cls_e   cls
);
    logic alt_hit;

    generate
        if (ALT_PROG_EN) begin : g_alt
            assign alt_hit = (code == 8'h10);
        end else begin : g_no_alt
            assign alt_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        case (code)
            8'hFF:   cls = CL_ARRAY;
            8'h90:   cls = CL_IDENT;
            8'h98:   cls = CL_QUERY;
            8'h70:   cls = CL_STAT;
            8'h50:   cls = CL_CLEAR;
            8'h20:   cls = CL_ERASE_SU;
            8'h40:   cls = CL_PROG_SU;
            8'h30:   cls = CL_FAST_SU;
            8'h60:   cls = CL_LOCK_SU;
            8'hC0:   cls = CL_PROT_SU;
            8'hB0:   cls = CL_SUSPEND;
            8'hD0:   cls = CL_CONFIRM;
            default: cls = alt_hit ? CL_PROG_SU : CL_OTHER;
        endcase
    end
endmodule

// File: rtl/fcd_status.sv
module fcd_status
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sr_upd_t    upd,
    output logic [7:0] sr_bits
);
    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (upd.clr_ready) sr_d.ready = 1'b0;
        if (upd.set_ready) sr_d.ready = 1'b1;
        if (upd.clr_err)   sr_d.err   = 1'b0;
        if (upd.set_err)   sr_d.err   = 1'b1;
        if (upd.clr_sus) begin
            sr_d.psus = 1'b0;
            sr_d.esus = 1'b0;
        end
        if (upd.set_psus)  sr_d.psus  = 1'b1;
        if (upd.set_esus)  sr_d.esus  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '{ready: 1'b1, esus: 1'b0, err: 1'b0, psus: 1'b0};
        end else begin
            sr_q <= sr_d;
        end
    end

    assign sr_bits = {sr_q.ready, sr_q.esus, 1'b0, sr_q.err, 1'b0, sr_q.psus, 2'b00};
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int AW          = 21,
    parameter int DW          = 16,
    parameter int BLK_W       = 15,
    parameter bit ALT_PROG_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          wsm_busy,
    output logic          req_stb,
    output logic [3:0]    req_op,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic [1:0]    rd_mode,
    output logic [7:0]    sr_bits
);
    localparam int BLK_MSB = AW - 1;
    localparam logic [DW-1:0] PLOCK_WORD = DW'(16'hFFFD);

    typedef struct packed {
        fsm_st_e       st;
        cmd_cls_e      setup;
        logic [AW-1:0] su_addr;
        rd_mode_e      mode;
        logic          req;
        req_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          busy;
    } ctl_t;

    ctl_t     r_d, r_q;
    cmd_cls_e cls;
    sr_upd_t  upd;
    fsm_st_e  cur_st;
    logic     wsm_done;
    logic     same_blk;
    logic     do_issue;
    logic     do_err;
    req_op_e  iss_op;
    fsm_st_e  iss_st;

    fcd_classify #(.ALT_PROG_EN(ALT_PROG_EN)) u_cls (
        .code (bus_wdata[7:0]),
        .cls  (cls)
    );

    fcd_status u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (upd),
        .sr_bits (sr_bits)
    );

    assign wsm_done = r_q.busy & ~wsm_busy;
    assign same_blk = (bus_addr[BLK_MSB:BLK_W] == r_q.su_addr[BLK_MSB:BLK_W]);
    assign cur_st   = r_q.st;

    always_comb begin
        fsm_st_e eff_st;
        r_d      = r_q;
        r_d.req  = 1'b0;
        r_d.busy = wsm_busy;
        upd      = '0;
        do_issue = 1'b0;
        do_err   = 1'b0;
        iss_op   = OP_NONE;
        iss_st   = ST_IDLE;
        eff_st   = r_q.st;

        // completion is taken first; a write in the same cycle sees idle
        if (is_run(r_q.st) && wsm_done) begin
            eff_st        = ST_IDLE;
            r_d.st        = ST_IDLE;
            upd.set_ready = 1'b1;
        end

        if (bus_we) begin
            case (eff_st)
                ST_IDLE, ST_SUS_PROG, ST_SUS_ERASE: begin
                    if (is_read_cls(cls)) begin
                        r_d.mode = mode_of(cls);
                    end else if (cls == CL_CLEAR) begin
                        upd.clr_err = 1'b1;
                    end else if (eff_st == ST_IDLE) begin
                        if (cls inside {CL_ERASE_SU, CL_PROG_SU, CL_FAST_SU,
                                        CL_LOCK_SU, CL_PROT_SU}) begin
                            r_d.st      = ST_SECOND;
                            r_d.setup   = cls;
                            r_d.su_addr = bus_addr;
                        end
                    end else if (cls == CL_CONFIRM) begin
                        r_d.req       = 1'b1;
                        r_d.op        = OP_RESUME;
                        r_d.addr      = bus_addr;
                        r_d.data      = bus_wdata;
                        r_d.mode      = RM_STATUS;
                        r_d.st        = (eff_st == ST_SUS_PROG) ? ST_RUN_PROG : ST_RUN_ERASE;
                        upd.clr_ready = 1'b1;
                        upd.clr_sus   = 1'b1;
                    end
                end
                ST_SECOND: begin
                    r_d.st = ST_IDLE;
                    case (r_q.setup)
                        CL_PROG_SU: begin
                            do_issue = 1'b1;
                            iss_op   = OP_PROG;
                            iss_st   = ST_RUN_PROG;
                        end
                        CL_FAST_SU: begin
                            do_issue = (cls == CL_CONFIRM);
                            iss_op   = OP_FAST;
                            iss_st   = ST_RUN_PROG;
                        end
                        CL_ERASE_SU: begin
                            do_issue = (cls == CL_CONFIRM) && same_blk;
                            iss_op   = OP_ERASE;
                            iss_st   = ST_RUN_ERASE;
                        end
                        CL_LOCK_SU: begin
                            iss_st = ST_RUN_FIXED;
                            case (bus_wdata[7:0])
                                8'h01: begin do_issue = 1'b1; iss_op = OP_LOCK;   end
                                8'hD0: begin do_issue = 1'b1; iss_op = OP_UNLOCK; end
                                8'h2F: begin do_issue = 1'b1; iss_op = OP_LOCKDN; end
                                default: do_issue = 1'b0;
                            endcase
                        end
                        CL_PROT_SU: begin
                            do_issue = 1'b1;
                            iss_op   = (bus_wdata == PLOCK_WORD) ? OP_PLOCK : OP_PPROG;
                            iss_st   = ST_RUN_FIXED;
                        end
                        default: do_issue = 1'b0;
                    endcase
                    do_err = ~do_issue;
                end
                ST_RUN_PROG, ST_RUN_ERASE: begin
                    if (cls == CL_SUSPEND) begin
                        r_d.req       = 1'b1;
                        r_d.op        = OP_SUSP;
                        r_d.addr      = bus_addr;
                        r_d.data      = bus_wdata;
                        upd.set_ready = 1'b1;
                        if (eff_st == ST_RUN_PROG) begin
                            upd.set_psus = 1'b1;
                            r_d.st       = ST_SUS_PROG;
                        end else begin
                            upd.set_esus = 1'b1;
                            r_d.st       = ST_SUS_ERASE;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (do_issue) begin
            r_d.req       = 1'b1;
            r_d.op        = iss_op;
            r_d.addr      = bus_addr;
            r_d.data      = bus_wdata;
            r_d.mode      = RM_STATUS;
            r_d.st        = iss_st;
            upd.clr_ready = 1'b1;
        end
        if (do_err) begin
            r_d.mode    = RM_STATUS;
            upd.set_err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, setup: CL_OTHER, su_addr: '0, mode: RM_ARRAY,
                     req: 1'b0, op: OP_NONE, addr: '0, data: '0, busy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_stb   = r_q.req;
    assign req_op    = r_q.op;
    assign req_addr  = r_q.addr;
    assign req_wdata = r_q.data;
    assign rd_mode   = r_q.mode;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import fcd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic [7:0] bus_code,
    input logic       req_stb,
    input logic [3:0] req_op,
    input logic [1:0] rd_mode,
    input logic [7:0] sr_bits,
    input fsm_st_e    cur_st
);
    // R10: every setup-driven request comes with status mode and ready low
    p_req_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && req_op >= 4'd1 && req_op <= 4'd8) |-> (rd_mode == 2'd3 && !sr_bits[7]));

    // R10: a running operation never reports ready
    p_run_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_run(cur_st) |-> !sr_bits[7]);

    // R11: a pulse always follows a host write
    p_req_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_stb |-> $past(bus_we));

    // R11: suspend sets ready and exactly one suspend flag
    p_suspend_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && req_op == 4'd9) |-> (sr_bits[7] && $countones({sr_bits[6], sr_bits[2]}) == 1));

    // R12: never both suspend flags
    p_sus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sr_bits[6], sr_bits[2]}));

    // R4: erase only after a confirm byte
    p_erase_confirm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stb && req_op == 4'd3) |-> ($past(bus_code) == 8'hD0));

    // R3: clear in idle drops the error flag
    p_clear_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_code == 8'h50 && cur_st == ST_IDLE) |=> !sr_bits[4]);
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_code (bus_wdata[7:0]),
    .req_stb  (req_stb),
    .req_op   (req_op),
    .rd_mode  (rd_mode),
    .sr_bits  (sr_bits),
    .cur_st   (cur_st)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        wsm_busy = 1'b0;
    logic        req_stb;
    logic [3:0]  req_op;
    logic [20:0] req_addr;
    logic [15:0] req_wdata;
    logic [1:0]  rd_mode;
    logic [7:0]  sr_bits;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .wsm_busy(wsm_busy), .req_stb(req_stb),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_mode(rd_mode), .sr_bits(sr_bits)
    );

    // reference model: phase 0 idle, 1 awaiting second, 2 program run,
    // 3 erase run, 4 unsuspendable run, 5 program held, 6 erase held
    int          m_phase = 0;
    int          m_first = 0;
    logic [20:0] m_first_addr = '0;
    int          m_mode = 0;
    bit          e_rdy = 1, e_err = 0, e_ps = 0, e_es = 0;
    bit          e_req = 0;
    int          e_op = 0;
    logic [20:0] e_addr = '0;
    logic [15:0] e_data = '0;
    bit          m_prev_busy = 0;

    function automatic int read_code(int c);
        if (c == 'hFF) return 0;
        if (c == 'h90) return 1;
        if (c == 'h98) return 2;
        if (c == 'h70) return 3;
        return -1;
    endfunction

    task automatic m_fire(int op, logic [20:0] a, logic [15:0] d);
        e_req = 1; e_op = op; e_addr = a; e_data = d;
    endtask

    task automatic m_write(logic [20:0] a, logic [15:0] d);
        int c = int'(d[7:0]);
        int rc = read_code(c);
        int op = 0;
        int nxt = 0;
        if (m_phase == 0 || m_phase == 5 || m_phase == 6) begin
            if (rc >= 0) m_mode = rc;
            else if (c == 'h50) e_err = 0;
            else if (m_phase == 0) begin
                if (c == 'h20 || c == 'h40 || c == 'h10 || c == 'h30 || c == 'h60 || c == 'hC0) begin
                    m_phase = 1; m_first = c; m_first_addr = a;
                end
            end else if (c == 'hD0) begin
                m_fire(10, a, d);
                e_rdy = 0; e_ps = 0; e_es = 0; m_mode = 3;
                m_phase = (m_phase == 5) ? 2 : 3;
            end
        end else if (m_phase == 1) begin
            if (m_first == 'h40 || m_first == 'h10) begin op = 1; nxt = 2; end
            else if (m_first == 'h30 && c == 'hD0) begin op = 2; nxt = 2; end
            else if (m_first == 'h20 && c == 'hD0 && (a >> 15) == (m_first_addr >> 15)) begin op = 3; nxt = 3; end
            else if (m_first == 'h60) begin
                nxt = 4;
                if (c == 'h01) op = 4;
                else if (c == 'hD0) op = 5;
                else if (c == 'h2F) op = 6;
            end else if (m_first == 'hC0) begin op = (d == 16'hFFFD) ? 8 : 7; nxt = 4; end
            m_mode = 3;
            if (op != 0) begin
                m_fire(op, a, d); e_rdy = 0; m_phase = nxt;
            end else begin
                e_err = 1; m_phase = 0;
            end
        end else if ((m_phase == 2 || m_phase == 3) && c == 'hB0) begin
            m_fire(9, a, d);
            e_rdy = 1;
            if (m_phase == 2) begin e_ps = 1; m_phase = 5; end
            else begin e_es = 1; m_phase = 6; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; e_rdy = 1; e_err = 0; e_ps = 0; e_es = 0;
            e_req = 0; e_op = 0; e_addr = '0; e_data = '0; m_prev_busy = 0;
        end else begin
            e_req = 0;
            if ((m_phase >= 2 && m_phase <= 4) && m_prev_busy && !wsm_busy) begin
                m_phase = 0; e_rdy = 1;
            end
            if (bus_we) m_write(bus_addr, bus_wdata);
            m_prev_busy = wsm_busy;
        end
    end

    task automatic compare();
        logic [7:0] exp_sr = {e_rdy, e_es, 1'b0, e_err, 1'b0, e_ps, 2'b00};
        total++;
        if (req_stb !== e_req || (e_req && (req_op !== 4'(e_op) ||
            req_addr !== e_addr || req_wdata !== e_data))) begin
            bad++;
            $display("FAIL %s request: got stb=%0b op=%0d a=%h d=%h exp stb=%0b op=%0d a=%h d=%h",
                     tag, req_stb, req_op, req_addr, req_wdata, e_req, e_op, e_addr, e_data);
        end
        total++;
        if (rd_mode !== 2'(m_mode)) begin
            bad++;
            $display("FAIL %s rd_mode: got %0d exp %0d", tag, rd_mode, m_mode);
        end
        total++;
        if (sr_bits !== exp_sr) begin
            bad++;
            $display("FAIL %s sr_bits: got %h exp %h", tag, sr_bits, exp_sr);
        end
    endtask

    task automatic cyc(bit we, logic [20:0] a, logic [15:0] d, bit busy);
        @(negedge clk);
        if (rst_n) compare();
        bus_we = we; bus_addr = a; bus_wdata = d; wsm_busy = busy;
    endtask

    task automatic wr(logic [20:0] a, logic [15:0] d, bit busy = 0);
        cyc(1, a, d, busy);
    endtask

    task automatic gap(int n, bit busy);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, busy);
    endtask

    task automatic finish_run(int n);
        gap(n, 1);
        gap(2, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        gap(3, 0);
        rst_n = 1'b1;
        gap(2, 0);
        // R1: reset values
        tag = "R1";
        total++;
        if (rd_mode !== 2'd0 || sr_bits !== 8'h80 || req_stb !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got mode=%0d sr=%h stb=%0b exp 0 80 0", rd_mode, sr_bits, req_stb);
        end

        tag = "R2";
        wr(21'h00010, 16'hAB90); wr(21'h00020, 16'h1298); wr(21'h0, 16'h0070);
        wr(21'h0, 16'h55FF); wr(21'h0, 16'h0033); wr(21'h0, 16'h00D0); wr(21'h0, 16'h00B0);
        gap(2, 0);

        tag = "R5";
        wr(21'h12345, 16'h0040); wr(21'h12346, 16'hBEEF);
        tag = "R11";
        gap(1, 1); wr(21'h0, 16'h00FF, 1); wr(21'h0, 16'h0050, 1); wr(21'h0, 16'h0020, 1);
        tag = "R10";
        finish_run(2);
        tag = "R5";
        wr(21'h00100, 16'h0010); wr(21'h00200, 16'h1234);
        tag = "R11";
        gap(2, 1); wr(21'h00200, 16'h00B0, 1); gap(2, 0);
        tag = "R12";
        wr(21'h0, 16'h0098); wr(21'h0, 16'h0020); wr(21'h0, 16'h00B0);
        wr(21'h00200, 16'h00D0); finish_run(3);

        tag = "R4";
        wr(21'h08000, 16'h0020); wr(21'h08123, 16'h00D0);
        gap(1, 1); wr(21'h08000, 16'h00B0, 1); gap(2, 0);
        tag = "R12";
        wr(21'h0, 16'h0090); wr(21'h08000, 16'h00D0); finish_run(2);
        tag = "R9";
        wr(21'h08000, 16'h0020); wr(21'h10000, 16'h00D0); gap(1, 0);
        tag = "R3";
        wr(21'h0, 16'h0050); gap(1, 0);
        tag = "R9";
        wr(21'h08000, 16'h0020); wr(21'h08000, 16'h0040); gap(1, 0);
        wr(21'h0, 16'h0050);

        tag = "R6";
        wr(21'h00400, 16'h0030); wr(21'h00404, 16'h00D0); finish_run(2);
        wr(21'h00400, 16'h0030); wr(21'h00404, 16'h0055); gap(1, 0); wr(21'h0, 16'h0050);

        tag = "R7";
        wr(21'h18000, 16'h0060); wr(21'h18000, 16'h0001);
        gap(1, 1); wr(21'h18000, 16'h00B0, 1); finish_run(1);
        wr(21'h18000, 16'h0060); wr(21'h18000, 16'h00D0); finish_run(2);
        wr(21'h18000, 16'h0060); wr(21'h18000, 16'h002F); finish_run(2);
        wr(21'h18000, 16'h0060); wr(21'h18000, 16'h0077); gap(1, 0); wr(21'h0, 16'h0050);

        tag = "R8";
        wr(21'h00080, 16'h00C0); wr(21'h00080, 16'hFFFD); finish_run(2);
        wr(21'h00084, 16'h00C0); wr(21'h00084, 16'h1234); finish_run(2);

        tag = "R13";
        wr(21'h00300, 16'h0040); wr(21'h00300, 16'hCAFE);
        gap(3, 1); wr(21'h0, 16'h00FF, 0); gap(2, 0);
        wr(21'h00300, 16'h0040); wr(21'h00300, 16'h0101);
        gap(2, 1); wr(21'h00500, 16'h0040, 0); wr(21'h00500, 16'h0202, 0);
        finish_run(2);
        gap(2, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule